// File: doc/BRIEF.md
# Battery-Backed Static Memory Controller

This block is a cycle-based model of a byte-wide static memory with nonvolatile supervision. The memory side has three active-low strobes (select, output-enable, write-strobe), an address bus and a data bus. The data bus is split into an input word, an output word and a drive-enable, which a pad ring joins into one bidirectional bus. Every pin is sampled on a fast system clock, and each pin passes through a two-flop synchronizer before any decision is made.

Four digital flags arrive from external supply comparators:
- supply above the full-operation level;
- supply above the write-lock level;
- supply above the cell-switchover level;
- supply above the seal-release level.

A supply state machine tracks these flags. In order, it starts in a sealed state, opens the seal on the first rise past the seal-release level, and then moves between normal operation, write lock and battery retention. Access is allowed only in normal operation. In every other state, writes are dropped, reads are ignored and the data drivers are off. Once the seal has opened, the battery select follows the switchover flag.

The memory interface is a pin-level strobe interface, not a valid/ready stream. It applies no back-pressure. A strobe pattern that arrives during normal operation is acted upon as it arrives. A pattern that arrives in any other state is discarded and never held for later.

Top module: `nvsram_ctl`

## Requirements
- R1: After reset the block is sealed: `dq_oe`=0, `bat_sel`=0 and `wr_prot`=1. The supply state encoding is SEALED=0, NORMAL=1, PROTECT=2, BATTERY=3.
- R2: In NORMAL, if `we_n` is high and both `ce_n` and `oe_n` are low, `dq_oe` goes to 1 and the byte at `addr` appears on `dq_out`. This happens three clock edges after the pins change.
- R3: A write window opens when the later of `ce_n` and `we_n` falls. It closes when the earlier of the two rises. The byte is stored at the address and data seen in the last cycle inside the window, so data changed after the close is not stored. The window may open with either strobe falling first and close with either strobe rising first.
- R4: If `we_n` falls while the data drivers are on, `dq_oe` returns to 0. The write then completes normally. When `we_n` rises again with `oe_n` still low, the new byte is driven.
- R5: In any state other than NORMAL, `wr_prot`=1, no write reaches the array and `dq_oe` stays 0 whatever the strobes do.
- R6: The block returns to NORMAL only when the full-operation flag is high. The write-lock flag alone keeps it in PROTECT, which gives hysteresis.
- R7: Once the seal is open, a low switchover flag sets `bat_sel`=1. When the switchover flag returns high, `bat_sel`=0.
- R8: While sealed, `bat_sel` stays 0 even if the switchover flag is low. The first high seal flag releases the seal permanently, and the block never re-enters SEALED.
- R9: Bytes written before a battery episode read back unchanged after the supply recovers to NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Data driver enable |
| sup_full | input | 1 | Supply above full-operation level |
| sup_wlock | input | 1 | Supply above write-lock level |
| sup_swover | input | 1 | Supply above cell-switchover level |
| sup_seal | input | 1 | Supply above seal-release level |
| bat_sel | output | 1 | Array powered from the backup cell |
| wr_prot | output | 1 | Writes and reads are locked out |

## Verification
The bound checker enforces these rules on every clock:
- no drive follows a locked cycle or a low synchronized write strobe;
- no array write happens outside NORMAL;
- the battery select is never raised while sealed;
- SEALED is never re-entered;
- NORMAL is entered only with the full-operation flag high;
- the battery select drops once the switchover flag returns.

Only the bench scenarios can show the following:
- stored bytes match, for each strobe ordering;
- data changed after a window closes is not stored;
- the new byte appears when the write strobe releases during a read;
- blocked writes leave the array unchanged;
- contents survive a battery episode.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    PS_SEALED  = 2'd0,
    PS_NORMAL  = 2'd1,
    PS_PROTECT = 2'd2,
    PS_BATTERY = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= g_st[i-1].r;
    end
  end
  assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/nvs_power_fsm.sv
module nvs_power_fsm
  import nvs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       f_full,
  input  logic       f_wlock,
  input  logic       f_swover,
  input  logic       f_seal,
  output pwr_state_e state_q,
  output logic       acc_en,
  output logic       bat_sel,
  output logic       wr_prot
);
  pwr_state_e nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      PS_SEALED:  if (f_seal) nxt = PS_PROTECT;
      PS_NORMAL:  if (!f_swover) nxt = PS_BATTERY;
                  else if (!f_wlock) nxt = PS_PROTECT;
      PS_PROTECT: if (!f_swover) nxt = PS_BATTERY;
                  else if (f_full) nxt = PS_NORMAL;
      PS_BATTERY: if (f_swover) nxt = PS_PROTECT;
      default:    nxt = PS_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= PS_SEALED;
    else        state_q <= nxt;

  assign acc_en  = (state_q == PS_NORMAL);
  assign wr_prot = (state_q != PS_NORMAL);
  assign bat_sel = (state_q == PS_BATTERY);
endmodule

// File: rtl/nvs_access.sv
module nvs_access #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en
);
  logic win_raw, win_q;

  // window is open while both select and write strobe are low
  assign win_raw = !ce_s && !we_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_q   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      win_q <= win_raw && acc_en;
      if (win_raw && acc_en) begin
        wr_addr <= addr_s;
        wr_data <= din_s;
      end
    end

  // commit in the cycle the window closes; a power drop aborts it
  assign wr_stb = win_q && !win_raw && acc_en;
  assign rd_en  = acc_en && !ce_s && !oe_s && we_s;
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (wr_stb) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      dq_oe <= rd_en;
      if (rd_en) begin
        if (wr_stb && (wr_addr == rd_addr)) dq_out <= wr_data;
        else                                dq_out <= mem[rd_addr];
      end
    end
endmodule

// File: rtl/nvsram_ctl.sv
module nvsram_ctl
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              sup_full,
  input  logic              sup_wlock,
  input  logic              sup_swover,
  input  logic              sup_seal,
  output logic              bat_sel,
  output logic              wr_prot
);
  localparam int PIN_W = 3 + ADDR_W + DATA_W;
  localparam logic [PIN_W-1:0] PIN_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic [PIN_W-1:0]  pin_s;
  logic [3:0]        flag_s;
  logic              ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              f_full_s, f_wlock_s, f_swover_s, f_seal_s;
  pwr_state_e        pwr_q;
  logic              acc_en;
  logic              wr_stb, rd_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  nvs_sync #(.W(PIN_W), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, oe_n, we_n, addr, dq_in}),
    .q(pin_s)
  );

  nvs_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b0000)) u_flag_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sup_full, sup_wlock, sup_swover, sup_seal}),
    .q(flag_s)
  );

  assign {ce_s, oe_s, we_s, addr_s, din_s} = pin_s;
  assign {f_full_s, f_wlock_s, f_swover_s, f_seal_s} = flag_s;

  nvs_power_fsm u_pwr (
    .clk(clk), .rst_n(rst_n),
    .f_full(f_full_s), .f_wlock(f_wlock_s),
    .f_swover(f_swover_s), .f_seal(f_seal_s),
    .state_q(pwr_q), .acc_en(acc_en),
    .bat_sel(bat_sel), .wr_prot(wr_prot)
  );

  nvs_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .din_s(din_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en)
  );

  nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(addr_s),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/nvsram_ctl_chk.sv
module nvsram_ctl_chk
  import nvs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pwr_state_e state,
  input logic       f_full_s,
  input logic       f_swover_s,
  input logic       we_s,
  input logic       wr_stb,
  input logic       dq_oe,
  input logic       bat_sel,
  input logic       wr_prot
);
  // R5: a locked cycle is never followed by a driven bus
  a_r5_locked_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prot |=> !dq_oe);

  // R5: the array only takes a write in NORMAL
  a_r5_commit_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (state == PS_NORMAL));

  // R4: a low write strobe turns the drivers off
  a_r4_we_low_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !we_s |=> !dq_oe);

  // R8: no battery path while sealed
  a_r8_sealed_main: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SEALED) |-> !bat_sel);

  // R8: seal release is permanent
  a_r8_no_reseal: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_SEALED) |=> (state != PS_SEALED));

  // R6: NORMAL is entered only with the full-operation flag
  a_r6_enter_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_prot) |-> $past(f_full_s));

  // R7: battery released once switchover flag returns
  a_r7_leave_battery: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_BATTERY) && f_swover_s) |=> !bat_sel);
endmodule

bind nvsram_ctl nvsram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(pwr_q),
  .f_full_s(f_full_s), .f_swover_s(f_swover_s), .we_s(we_s),
  .wr_stb(wr_stb), .dq_oe(dq_oe), .bat_sel(bat_sel), .wr_prot(wr_prot)
);

// File: tb/test_nvsram_ctl.sv
module test_nvsram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, bat_sel, wr_prot;
  logic sup_full = 1'b0, sup_wlock = 1'b0, sup_swover = 1'b0, sup_seal = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [int];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsram_ctl #(.ADDR_W(AW), .DATA_W(DW)) i_nvsram_ctl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .sup_full(sup_full), .sup_wlock(sup_wlock), .sup_swover(sup_swover),
    .sup_seal(sup_seal), .bat_sel(bat_sel), .wr_prot(wr_prot)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic power(input logic f, input logic w, input logic s, input logic sl);
    sup_full = f; sup_wlock = w; sup_swover = s; sup_seal = sl;
    step(6);
  endtask

  // order 0: ce falls first, we rises first
  // order 1: we falls first, ce rises first
  // order 2: ce falls first, ce rises first
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int order, input bit commit);
    addr = a; dq_in = d; step(2);
    if (order == 1) we_n = 1'b0; else ce_n = 1'b0;
    step(4);
    if (order == 1) ce_n = 1'b0; else we_n = 1'b0;
    step(4);
    if (order == 0) we_n = 1'b1; else ce_n = 1'b1;
    step(1);
    dq_in = ~d;
    step(4);
    ce_n = 1'b1; we_n = 1'b1;
    step(4);
    if (commit) model[int'(a)] = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    addr = a;
    exp_q.push_back(model[int'(a)]);
    tag_q.push_back(req);
    step(1);
    ce_n = 1'b0; oe_n = 1'b0;
    step(5);
    ce_n = 1'b1; oe_n = 1'b1;
    step(3);
  endtask

  task automatic rd_blocked(input logic [AW-1:0] a, input string req);
    addr = a; step(1);
    ce_n = 1'b0; oe_n = 1'b0;
    step(5);
    chk(req, 16'(dq_oe), 16'h0);
    ce_n = 1'b1; oe_n = 1'b1;
    step(3);
  endtask

  // scoreboard monitor: each new drive episode pops one expected byte
  always @(negedge clk) begin
    if (rst_n && dq_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual unexpected drive %0h expected no drive", dq_out);
      end else begin
        chk(tag_q.pop_front(), 16'(dq_out), 16'(exp_q.pop_front()));
      end
    end
    oe_prev = dq_oe;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 dq_oe", 16'(dq_oe), 16'h0);
    chk("R1 bat_sel", 16'(bat_sel), 16'h0);
    chk("R1 wr_prot", 16'(wr_prot), 16'h1);
    rst_n = 1'b1;
    step(3);

    // R8: switchover flag low while sealed, no battery path
    power(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 sealed bat_sel", 16'(bat_sel), 16'h0);
    rd_blocked(11'h010, "R5 sealed read");

    // release the seal, then write-lock level only
    power(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 released locked", 16'(wr_prot), 16'h1);
    power(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 wlock only stays locked", 16'(wr_prot), 16'h1);
    power(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R6 full level unlocks", 16'(wr_prot), 16'h0);

    // R3: each strobe ordering
    wr(11'h010, 8'hA5, 0, 1'b1);
    wr(11'h3FF, 8'h5C, 1, 1'b1);
    wr(11'h7FF, 8'h81, 2, 1'b1);
    wr(11'h000, 8'h00, 0, 1'b1);
    rd(11'h010, "R3 order ce-first we-rise");
    rd(11'h3FF, "R3 order we-first ce-rise");
    rd(11'h7FF, "R3 order ce-first ce-rise");
    rd(11'h000, "R2 zero byte");
    rd(11'h010, "R2 repeat read");

    // R4: write strobe falls during a read
    addr = 11'h020; dq_in = 8'h3C; step(1);
    wr(11'h020, 8'h3C, 0, 1'b1);
    exp_q.push_back(8'h3C); tag_q.push_back("R4 before write");
    ce_n = 1'b0; oe_n = 1'b0;
    step(5);
    dq_in = 8'hC7; we_n = 1'b0;
    step(5);
    chk("R4 drivers off", 16'(dq_oe), 16'h0);
    exp_q.push_back(8'hC7); tag_q.push_back("R4 new byte driven");
    we_n = 1'b1;
    step(6);
    ce_n = 1'b1; oe_n = 1'b1;
    model[32'h20] = 8'hC7;
    step(3);
    rd(11'h020, "R4 stored after read overlap");

    // R5: locked supply blocks writes and reads
    power(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 wr_prot", 16'(wr_prot), 16'h1);
    wr(11'h010, 8'hFF, 0, 1'b0);
    rd_blocked(11'h010, "R5 locked read");
    power(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 hysteresis", 16'(wr_prot), 16'h1);
    power(1'b1, 1'b1, 1'b1, 1'b1);
    rd(11'h010, "R5 blocked write left byte");

    // R7/R9: battery episode with seal flag gone
    power(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 battery select", 16'(bat_sel), 16'h1);
    chk("R8 seal stays released", 16'(bat_sel), 16'h1);
    rd_blocked(11'h3FF, "R5 battery read");
    power(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 main supply back", 16'(bat_sel), 16'h0);
    chk("R7 still locked", 16'(wr_prot), 16'h1);
    power(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R6 normal after recovery", 16'(wr_prot), 16'h0);
    rd(11'h3FF, "R9 kept through battery");
    rd(11'h020, "R9 kept through battery");

    step(4);
    chk("R2 all reads seen", 16'(exp_q.size()), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule